// File: doc/BRIEF.md
# Strided Stream Address Generator

This block turns queued stream commands into a series of word-aligned memory or scratchpad requests. Each command gives a start address, an access size in bytes, a stride and a count of elements. Element i covers `size` bytes starting at `start + i*stride`, for i from 0 to count-1. Strides smaller than the size, which give overlapping elements, are legal. A stride of zero, which repeats one element, is also legal. In indirect mode the stride is ignored. Each element address is then the command's start (used as a base) plus an index value taken from an index port, and the command ends after `count` indices.

Up to four commands are held in slots. The lowest-numbered occupied slot always owns the request port. Requests leave through a valid/ready handshake and carry an 8-byte-aligned word address, a byte mask and the command's destination port. An element that crosses a word boundary is split into two requests, the lower word first. When a command's last request is accepted, its slot is freed and a one-cycle done bit is raised for that slot.

Top module: `stream_agen`

## Requirements
- R1: An affine command issues its elements in order i = 0 .. count-1, and element i covers the bytes start + i*stride through start + i*stride + size - 1.
- R2: Every request has req_addr[2:0] = 0, and req_mask bit b selects byte req_addr + b. An element whose bytes span two words is issued as two requests, the lower word first.
- R3: Overlapping patterns (stride < size) and repeating patterns (stride = 0) are generated in full, one element per stride.
- R4: In indirect mode each element address is start + idx_value. One index is consumed per element, and only while that command owns the request port (idx_ready high, req_valid low until the index arrives).
- R5: Up to 4 commands are held. cmd_ready is low exactly when all slots are occupied, and an accepted command takes the lowest-numbered free slot.
- R6: Requests always come from the lowest-numbered occupied slot. A newly accepted command in a lower slot takes over, and the interrupted command later resumes where it stopped.
- R7: In the cycle after a command's last request is accepted, done_vec raises the bit of that command's slot for exactly one cycle, and the slot becomes free.
- R8: A command with count 0 or size 0 issues no requests. Its slot's done bit pulses in the cycle after the command is accepted.
- R9: While req_valid is high and req_ready is low, the request and the pattern position hold. No request is dropped or duplicated.
- R10: A size field above 8 is treated as 8 bytes.
- R11: After reset all slots are free: cmd_ready is 1, and req_valid, idx_ready and done_vec are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | A slot is free |
| cmd_indirect | input | 1 | 1 = addresses come from the index port |
| cmd_start | input | 32 | Start byte address, or base in indirect mode |
| cmd_size | input | 4 | Bytes per element (values above 8 are treated as 8) |
| cmd_stride | input | 32 | Byte distance between elements (affine mode) |
| cmd_count | input | 16 | Number of elements |
| cmd_port | input | 4 | Destination port tag |
| idx_valid | input | 1 | Index value offered |
| idx_ready | output | 1 | Index consumed for the owning indirect command |
| idx_value | input | 32 | Byte offset added to the base |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | 32 | 8-byte-aligned word address |
| req_mask | output | 8 | Byte enables within the word |
| req_port | output | 4 | Destination port tag |
| done_vec | output | 4 | One-cycle completion pulse per slot |

## Verification
The hardest situation to reach is a command in a lower slot taking over from a command that is halfway through its pattern, possibly in the middle of a split element. The stimulus creates it by holding req_ready low while a short command and a long command fill slots 0 and 1. It then releases the port so the short one drains. A third command offered next lands in the freed slot 0 and takes over from the long one. Random back-pressure also lands stalls on the second half of split elements. The per-cycle model checks that every accepted request matches the next one expected for the owning slot.

// File: rtl/stream_agen.sv
module stream_agen #(
  parameter int SLOTS = 4,
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int PW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_indirect,
  input  logic [AW-1:0]    cmd_start,
  input  logic [3:0]       cmd_size,
  input  logic [AW-1:0]    cmd_stride,
  input  logic [CW-1:0]    cmd_count,
  input  logic [PW-1:0]    cmd_port,
  input  logic             idx_valid,
  output logic             idx_ready,
  input  logic [AW-1:0]    idx_value,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [7:0]       req_mask,
  output logic [PW-1:0]    req_port,
  output logic [SLOTS-1:0] done_vec
);
  localparam int SIDW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] vld, ind, half, have;
  logic [AW-1:0]    addr   [SLOTS];
  logic [AW-1:0]    base   [SLOTS];
  logic [AW-1:0]    stride [SLOTS];
  logic [3:0]       size   [SLOTS];
  logic [CW-1:0]    cnt    [SLOTS];
  logic [PW-1:0]    port   [SLOTS];

  logic [SIDW-1:0] sel, fslot;
  logic            sel_any, free_any;

  always_comb begin
    sel = '0; sel_any = 1'b0; fslot = '0; free_any = 1'b0;
    for (int k = SLOTS-1; k >= 0; k--) begin
      if (vld[k])  begin sel   = SIDW'(k); sel_any  = 1'b1; end
      if (!vld[k]) begin fslot = SIDW'(k); free_any = 1'b1; end
    end
  end

  logic [AW-1:0] cur, wbase;
  logic [15:0]   m16;
  logic          split, fire, elem_end, last, cmd_fire, cmd_empty;
  logic [3:0]    sz_eff;

  assign cur      = addr[sel];
  assign wbase    = {cur[AW-1:3], 3'b000};
  assign m16      = ((16'd1 << size[sel]) - 16'd1) << cur[2:0];
  assign split    = |m16[15:8];
  assign req_valid = sel_any && (!ind[sel] || have[sel]);
  assign idx_ready = sel_any && ind[sel] && !have[sel];
  assign req_addr = half[sel] ? wbase + AW'(8) : wbase;
  assign req_mask = half[sel] ? m16[15:8] : m16[7:0];
  assign req_port = port[sel];
  assign fire     = req_valid && req_ready;
  assign elem_end = fire && (half[sel] || !split);
  assign last     = elem_end && (cnt[sel] == CW'(1));
  assign cmd_ready = free_any;
  assign cmd_fire  = cmd_valid && free_any;
  assign cmd_empty = (cmd_size == 4'd0) || (cmd_count == '0);
  assign sz_eff    = (cmd_size > 4'd8) ? 4'd8 : cmd_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; ind <= '0; half <= '0; have <= '0; done_vec <= '0;
    end else begin
      done_vec <= '0;
      if (fire && !elem_end) half[sel] <= 1'b1;
      if (elem_end) begin
        half[sel] <= 1'b0;
        if (last) begin
          vld[sel]      <= 1'b0;
          done_vec[sel] <= 1'b1;
        end else begin
          cnt[sel] <= cnt[sel] - CW'(1);
          if (ind[sel]) have[sel] <= 1'b0;
          else          addr[sel] <= cur + stride[sel];
        end
      end
      if (idx_ready && idx_valid) begin
        addr[sel] <= base[sel] + idx_value;
        have[sel] <= 1'b1;
      end
      if (cmd_fire) begin
        if (cmd_empty) done_vec[fslot] <= 1'b1;
        else begin
          vld[fslot]    <= 1'b1;
          ind[fslot]    <= cmd_indirect;
          half[fslot]   <= 1'b0;
          have[fslot]   <= 1'b0;
          addr[fslot]   <= cmd_start;
          base[fslot]   <= cmd_start;
          stride[fslot] <= cmd_stride;
          size[fslot]   <= sz_eff;
          cnt[fslot]    <= cmd_count;
          port[fslot]   <= cmd_port;
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !(cmd_valid && cmd_ready) |=>
      req_valid && $stable(req_addr) && $stable(req_mask) && $stable(req_port)); // R9
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_mask != 8'd0); // R2
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_vec) |-> $past((req_valid && req_ready) || (cmd_valid && cmd_ready))); // R7
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(done_vec) <= 2); // R8
  AST_IDX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> !req_valid); // R4
endmodule

// File: tb/stream_agen_tb.sv
`timescale 1ns/1ps
module stream_agen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_indirect = 1'b0;
  logic [31:0] cmd_start = '0, cmd_stride = '0;
  logic [3:0] cmd_size = '0, cmd_port = '0;
  logic [15:0] cmd_count = '0;
  logic idx_valid = 1'b0;
  logic [31:0] idx_value = '0;
  logic req_ready = 1'b1;
  logic cmd_ready, idx_ready, req_valid;
  logic [31:0] req_addr;
  logic [7:0] req_mask;
  logic [3:0] req_port, done_vec;

  always #2.5 clk = ~clk;

  stream_agen dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_indirect(cmd_indirect), .cmd_start(cmd_start), .cmd_size(cmd_size),
    .cmd_stride(cmd_stride), .cmd_count(cmd_count), .cmd_port(cmd_port),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_value(idx_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_mask(req_mask), .req_port(req_port), .done_vec(done_vec));

  int checks = 0, errors = 0;
  string tag = "R11";
  int ready_mode = 0;
  logic [43:0] mq [4][$];
  logic [31:0] pend_idx[$];
  logic [31:0] idx_src[$];
  bit idx_take = 0;
  bit [3:0] occ = '0, mind = '0, exp_done = '0;

  task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic build(input int slot, input bit ind, input logic [31:0] st, input logic [3:0] sz,
                       input logic [31:0] strd, input int cnt, input logic [3:0] pt);
    int s;
    s = (sz > 8) ? 8 : int'(sz);
    if (s == 0) return;
    for (int i = 0; i < cnt; i++) begin
      logic [31:0] a, w;
      logic [15:0] m;
      a = ind ? st + pend_idx.pop_front() : st + strd * 32'(i);
      w = {a[31:3], 3'b000};
      m = ((16'd1 << s) - 16'd1) << a[2:0];
      mq[slot].push_back({pt, w, m[7:0]});
      if (m[15:8] != 0) mq[slot].push_back({pt, w + 32'd8, m[15:8]});
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit [3:0] occ0, nxt;
    int lo, fr;
    occ0 = occ; nxt = '0; lo = -1; fr = -1;
    for (int k = 3; k >= 0; k--) begin
      if (occ0[k]) lo = k;
      if (!occ0[k]) fr = k;
    end
    chk(done_vec == exp_done, (exp_done != 0) ? tag : "R7", 64'(done_vec), 64'(exp_done));
    if (lo < 0) begin
      chk(!req_valid, "R6", 64'(req_valid), 0);
      chk(!idx_ready, "R4", 64'(idx_ready), 0);
    end else if (!mind[lo]) chk(req_valid, "R9", 64'(req_valid), 1);
    if (req_valid && req_ready) begin
      if (lo < 0 || mq[lo].size() == 0) chk(0, "R6", 64'({req_port, req_addr, req_mask}), 0);
      else begin
        logic [43:0] e;
        e = mq[lo].pop_front();
        chk({req_port, req_addr, req_mask} == e, tag, 64'({req_port, req_addr, req_mask}), 64'(e));
        if (mq[lo].size() == 0) begin occ[lo] = 0; nxt[lo] = 1; end
      end
    end
    chk(cmd_ready == (occ0 != 4'hF), "R5", 64'(cmd_ready), 64'(occ0 != 4'hF));
    if (cmd_valid && cmd_ready && fr >= 0) begin
      build(fr, cmd_indirect, cmd_start, cmd_size, cmd_stride, int'(cmd_count), cmd_port);
      if (mq[fr].size() == 0) nxt[fr] = 1;
      else begin occ[fr] = 1; mind[fr] = cmd_indirect; end
    end
    if (idx_valid && idx_ready) idx_take = 1;
    exp_done = nxt;
  end

  initial forever begin
    @(posedge clk); #1;
    req_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 2) ? 1'b0 : 1'($urandom % 2);
  end

  initial forever begin
    @(posedge clk); #1;
    if (idx_take) begin void'(idx_src.pop_front()); idx_take = 0; end
    idx_valid = idx_src.size() != 0;
    idx_value = (idx_src.size() != 0) ? idx_src[0] : '0;
  end

  task automatic send(input bit ind, input logic [31:0] st, input logic [3:0] sz,
                      input logic [31:0] strd, input logic [15:0] cnt, input logic [3:0] pt);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_indirect = ind; cmd_start = st; cmd_size = sz;
    cmd_stride = strd; cmd_count = cnt; cmd_port = pt;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (occ != 0 || exp_done != 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1, "R11", 64'(cmd_ready), 1);
    chk(req_valid == 0, "R11", 64'(req_valid), 0);
    chk(idx_ready == 0, "R11", 64'(idx_ready), 0);
    chk(done_vec == 0, "R11", 64'(done_vec), 0);

    tag = "R1";
    send(0, 32'hA, 4, 8, 2, 1);
    send(0, 32'h100, 8, 16, 3, 2);
    wait_idle();
    tag = "R2";
    send(0, 32'h6, 4, 8, 3, 3);
    send(0, 32'h7, 8, 32'h20, 2, 4);
    wait_idle();
    tag = "R3";
    send(0, 32'h40, 4, 2, 4, 5);
    send(0, 32'h55, 3, 0, 3, 6);
    wait_idle();
    tag = "R10";
    send(0, 32'h31, 15, 8, 2, 7);
    wait_idle();
    tag = "R8";
    send(0, 32'h10, 0, 8, 5, 1);
    send(0, 32'h10, 4, 8, 0, 1);
    wait_idle();

    tag = "R5";
    ready_mode = 2;
    send(0, 32'h200, 2, 4, 2, 1);
    send(0, 32'h300, 8, 8, 2, 2);
    send(0, 32'h403, 6, 12, 2, 3);
    send(0, 32'h500, 1, 1, 3, 4);
    @(negedge clk);
    chk(cmd_ready == 0, "R5", 64'(cmd_ready), 0);
    ready_mode = 0;
    wait_idle();

    tag = "R6";
    ready_mode = 2;
    send(0, 32'h600, 4, 4, 1, 1);
    send(0, 32'h705, 6, 10, 30, 2);
    ready_mode = 1;
    repeat (12) @(posedge clk);
    send(0, 32'h800, 8, 24, 4, 3);
    wait_idle();

    tag = "R9";
    ready_mode = 1;
    send(0, 32'h903, 7, 9, 10, 4);
    send(0, 32'hA05, 5, 3, 8, 5);
    wait_idle();

    tag = "R4";
    ready_mode = 0;
    pend_idx = '{32'h3, 32'h20, 32'h1C, 32'h100};
    send(1, 32'h1000, 4, 0, 4, 9);
    repeat (3) @(negedge clk);
    chk(idx_ready == 1, "R4", 64'(idx_ready), 1);
    chk(req_valid == 0, "R4", 64'(req_valid), 0);
    @(posedge clk); #1;
    idx_src.push_back(32'h3); idx_src.push_back(32'h20);
    idx_src.push_back(32'h1C); idx_src.push_back(32'h100);
    ready_mode = 1;
    wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule